// File: doc/BRIEF.md
# Indirect Test-RAM Access Window

This block holds a word-organised test memory of 1024 words of 32 bits. Software reaches it through two registers on one request port. The pointer register takes a byte address. The data window register reads or writes the word that the pointer selects. Bit 31 of the pointer turns on auto-advance. When it is set, every read or write of the data window moves the pointer on by one word (4 bytes) in the same cycle. Software can then stream a block of words without rewriting the pointer.

Requests arrive on a valid/ready handshake. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` stays low after reset while the memory is being zeroed, one word per cycle, and stays high afterwards. Every accepted read gives a response one cycle later. The response carries no back-pressure: the consumer must take `rsp_data` in the cycle that `rsp_valid` is high. Writes give no response.

Top module: `indirect_ram_port`

## Requirements
- R1: After reset is released, `req_ready` is low for exactly 1024 cycles while the memory is cleared, and high from then on.
- R2: A write to the pointer register (`req_sel`=0) stores bits 15:0 as the byte address and bit 31 as the auto-advance flag. Reading it back returns the flag in bit 31 and the address in bits 15:0, with bits 30:16 reading zero. After reset it reads zero.
- R3: A write to the data window (`req_sel`=1) stores `req_wdata` in the word whose index is pointer bits 11:2. Pointer bits 1:0 have no effect on which word is selected.
- R4: A read of the data window returns the word at pointer bits 11:2. Every accepted read, of either register, raises `rsp_valid` for exactly the next cycle, with `rsp_data` valid in that cycle.
- R5: When the auto-advance flag is set, each accepted data-window access adds 4 to the pointer. The access itself uses the pointer value from before the step.
- R6: When the auto-advance flag is clear, data-window accesses leave the pointer unchanged.
- R7: Pointer bits 15:12 are ignored for word selection, so address 0x1004 reaches the same word as 0x0004.
- R8: Every memory word reads zero after any reset, even words written before that reset.
- R9: The pointer advance wraps within 16 bits, so 0xFFFC steps to 0x0000.
- R10: A request has no effect when `req_valid` is low or `req_ready` is low. Writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = pointer register, 1 = data window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present, one cycle only |
| rsp_data | output | 32 | Read response data |

## Verification
The assertions assume that `req_sel` and `req_write` are meaningful only in a cycle where a request is accepted. They also assume that nothing drives the memory while it is being cleared, which holds because every access is gated by `req_ready`. The bench changes its inputs only on falling edges and waits for `req_ready` before it issues any request, apart from one deliberate attempt during clearing that checks the request is ignored. It reads responses exactly one cycle after each read is taken, so no response is ever dropped for lack of back-pressure.

// File: rtl/ira_pkg.sv
package ira_pkg;
  typedef enum logic {
    SEL_PTR = 1'b0,
    SEL_WIN = 1'b1
  } win_sel_e;

  localparam int unsigned PTR_FLAG_BIT = 31;
endpackage

// File: rtl/ira_addr_reg.sv
module ira_addr_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              win_acc,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              adv_q
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      adv_q <= 1'b0;
    end else if (ptr_wr) begin
      ptr_q <= wdata[ADDR_W-1:0];
      adv_q <= wdata[ira_pkg::PTR_FLAG_BIT];
    end else if (win_acc && adv_q) begin
      ptr_q <= ptr_q + STEP_V;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && adv_q && !ptr_wr) |=> (ptr_q == $past(ptr_q) + STEP_V)); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !(win_acc && adv_q)) |=> $stable(ptr_q)); // R6

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (adv_q == $past(wdata[ira_pkg::PTR_FLAG_BIT]))); // R2
endmodule

// File: rtl/ira_mem.sv
module ira_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              clearing
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [DATA_W-1:0] store [WORDS];
  logic [IDX_W-1:0]  clr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_idx  <= '0;
      clearing <= 1'b1;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == LAST_IDX) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && clearing) store[clr_idx] <= '0;
    else if (rst_n && we)  store[idx]     <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[idx];
  end

  AST_NO_ACCESS_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !(we || re)); // R1

  AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clearing && clr_idx == LAST_IDX) |=> !clearing); // R8
endmodule

// File: rtl/indirect_ram_port.sv
module indirect_ram_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 1024,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned LSB   = $clog2(BYTES),
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import ira_pkg::*;

  logic              clearing;
  logic              take;
  logic              ptr_wr, win_wr, win_rd, rd_any, win_acc;
  logic [ADDR_W-1:0] ptr_q;
  logic              adv_q;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] ptr_view_q;
  logic              rsp_sel_q;

  assign req_ready = !clearing;
  assign take      = req_valid && req_ready;
  assign ptr_wr    = take && req_write  && (win_sel_e'(req_sel) == SEL_PTR);
  assign win_wr    = take && req_write  && (win_sel_e'(req_sel) == SEL_WIN);
  assign win_rd    = take && !req_write && (win_sel_e'(req_sel) == SEL_WIN);
  assign rd_any    = take && !req_write;
  assign win_acc   = win_wr || win_rd;

  ira_addr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .wdata(req_wdata),
    .win_acc(win_acc), .ptr_q(ptr_q), .adv_q(adv_q)
  );

  ira_mem #(.DATA_W(DATA_W), .WORDS(WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(win_wr), .re(win_rd),
    .idx(ptr_q[LSB +: IDX_W]), .wdata(req_wdata),
    .rdata(mem_rdata), .clearing(clearing)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_sel_q  <= 1'b0;
      ptr_view_q <= '0;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) begin
        rsp_sel_q  <= req_sel;
        ptr_view_q <= '0;
        ptr_view_q[ADDR_W-1:0]   <= ptr_q;
        ptr_view_q[PTR_FLAG_BIT] <= adv_q;
      end
    end
  end

  assign rsp_data = rsp_sel_q ? mem_rdata : ptr_view_q;

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid); // R4

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid); // R10

  AST_READY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |=> req_ready); // R1
endmodule

// File: tb/tb_indirect_ram_port.sv
module tb_indirect_ram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_sel = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  indirect_ram_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 no rsp on write", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
    d = rsp_data;
    @(negedge clk);
    check("R4 rsp_valid one cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int cnt = 0;
    do_reset();
    check("R1 ready low at release", {31'b0, req_ready}, 32'd0);
    while (!req_ready) begin @(negedge clk); cnt++; end
    check("R1 clear cycles", cnt, 32'd1024);
    rd(1'b0, v); check("R2 pointer reset", v, 32'd0);
    rd(1'b1, v); check("R8 word0 zero", v, 32'd0);
  endtask

  task automatic t_ptr_rw();
    logic [31:0] v;
    wr(1'b0, 32'hFFFF_1238);
    rd(1'b0, v); check("R2 pointer readback", v, 32'h8000_1238);
    wr(1'b0, 32'h7FFF_0010);
    rd(1'b0, v); check("R2 flag clear readback", v, 32'h0000_0010);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0020);
    wr(1'b1, 32'hA5A5_0001);
    rd(1'b0, v); check("R6 no advance on write", v, 32'h0000_0020);
    rd(1'b1, v); check("R3/R4 read back word 8", v, 32'hA5A5_0001);
    rd(1'b0, v); check("R6 no advance on read", v, 32'h0000_0020);
    wr(1'b0, 32'h0000_0023);
    rd(1'b1, v); check("R3 low bits ignored", v, 32'hA5A5_0001);
  endtask

  task automatic t_autoinc();
    logic [31:0] v;
    wr(1'b0, 32'h8000_0100);
    for (int i = 0; i < 4; i++) wr(1'b1, 32'hC0DE_0000 + i);
    rd(1'b0, v); check("R5 advance after writes", v, 32'h8000_0110);
    wr(1'b0, 32'h8000_0100);
    for (int i = 0; i < 4; i++) begin
      rd(1'b1, v); check("R5 burst read", v, 32'hC0DE_0000 + i);
    end
    rd(1'b0, v); check("R5 advance after reads", v, 32'h8000_0110);
  endtask

  task automatic t_alias_wrap();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0004);
    wr(1'b1, 32'h1234_5678);
    wr(1'b0, 32'h0000_1004);
    rd(1'b1, v); check("R7 upper bits ignored", v, 32'h1234_5678);
    wr(1'b0, 32'h8000_FFFC);
    wr(1'b1, 32'h0BAD_F00D);
    rd(1'b0, v); check("R9 pointer wrap", v, 32'h8000_0000);
    wr(1'b0, 32'h0000_0FFC);
    rd(1'b1, v); check("R7 0xFFFC aliases 0xFFC", v, 32'h0BAD_F00D);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0040);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_sel = 1'b1; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_sel = 1'b0; req_wdata = 32'h8000_0080;
    @(negedge clk);
    check("R10 idle no rsp", {31'b0, rsp_valid}, 32'd0);
    rd(1'b0, v); check("R10 pointer untouched", v, 32'h0000_0040);
    rd(1'b1, v); check("R10 word untouched", v, 32'd0);
  endtask

  task automatic t_rereset();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0020);
    wr(1'b1, 32'h5555_AAAA);
    do_reset();
    req_valid = 1'b1; req_write = 1'b1; req_sel = 1'b1; req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    wr(1'b0, 32'h0000_0020);
    rd(1'b1, v); check("R8 cleared after reset", v, 32'd0);
    wr(1'b0, 32'h0000_0000);
    rd(1'b1, v); check("R10 write during clear ignored", v, 32'd0);
  endtask

  initial begin
    t_reset();
    t_ptr_rw();
    t_plain();
    t_autoinc();
    t_alias_wrap();
    t_ignored();
    t_rereset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule